// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between a processor-side register port and the bit shifter of an SPI controller. It holds a transmit queue that software fills one word at a time and a shift engine drains, and a receive queue that the engine fills and software drains. Around the two queues it keeps the software-visible control, status, interrupt-enable, queue-threshold and fill-level words, and it drives a single interrupt line. Clock division and bit shifting belong to the engine and are not part of this unit.

Software addresses one 32-bit word per access through plain read and write strobes on a 4-bit word address: 0 parameters, 1 control, 2 status, 3 interrupt enable, 4 queue thresholds, 5 fill levels, 6 receive state, 8 transmit data (write), 9 receive data (read). Read data is combinational from the address. A read of address 9 both returns the oldest receive word and removes it. The engine sees a valid/pop pair on the transmit side and a push strobe on the receive side, and reports a busy level and an end-of-frame pulse that marks chip-select deasserting.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the status word reads 0x00000001, the receive-state word reads 0x00000002, and control, interrupt enable, thresholds and fill levels read zero with the interrupt low.
- R2: Writes to address 8 enter the transmit queue in order and are dropped when it is full; the fill level reads in bits 7:0 of address 5; the engine sees `eng_tx_valid` with the oldest word only while control bit 0 (enable) is 1 and the queue is not empty, and `eng_tx_pop` removes that word.
- R3: While enabled, `eng_rx_push` stores a word unless the receive queue is full; pushes while disabled are dropped; a read of address 9 returns and removes the oldest word, and on an empty queue returns zero with the count unchanged; the receive fill level reads in bits 18:16 of address 5 and bit 1 of address 6 is 1 exactly while the receive queue is empty.
- R4: Status bit 0 is 1 while the transmit fill level is at or below the transmit threshold held in the low bits of address 4.
- R5: Status bit 1 is 1 while the receive fill level is above the receive threshold held from bit 16 of address 4.
- R6: Status bit 9 sets on an `eng_frame_end` pulse and holds until cleared.
- R7: Status bit 10 sets in the cycle after the transmit queue becomes empty with `eng_busy` low, or `eng_busy` falls with the queue empty, and holds until cleared.
- R8: Status bits 13:8 clear where a 1 is written to them (0x3F00 clears all), a written 0 leaves them, a set event in the same cycle as its clear wins, and writes to bits 0, 1 and 24 have no effect.
- R9: Status bit 24 reads 1 while enabled and `eng_busy` is high.
- R10: Interrupt-enable bits 0, 1, 9 and 10 are stored (others read 0) and `irq` is the OR of each enabled status bit at the same position.
- R11: Writing control with bit 8 (bit 9) set empties the transmit (receive) queue by the next cycle, the bit reads back 0, and an engine push in that same cycle is lost.
- R12: Writing control with bit 1 set returns all state to its reset value in the next cycle; the bit reads back 0.
- R13: Address 0 reads the transmit depth as log2 in bits 3:0 and the receive depth as log2 in bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 9) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_busy | input | 1 | Engine is shifting |
| eng_frame_end | input | 1 | Pulse: frame ended, chip-select deasserting |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with both queues four words deep (TX_LOG2 = RX_LOG2 = 2). At that depth a handful of writes reaches the full transmit queue and the dropped fifth word, the two-bit transmit threshold can sit at the top value 3 so the transmit flag is seen on both sides of it, and the receive threshold of 1 puts the receive flag edge between one and two stored words. The same depth keeps the flush, empty-read and reset cases only a few cycles apart.

// File: rtl/spi_fis_pkg.sv
package spi_fis_pkg;

  typedef enum logic [3:0] {
    A_PARAM  = 4'd0,
    A_CTRL   = 4'd1,
    A_STAT   = 4'd2,
    A_IEN    = 4'd3,
    A_FCTL   = 4'd4,
    A_FSTAT  = 4'd5,
    A_RXSTAT = 4'd6,
    A_TXDATA = 4'd8,
    A_RXDATA = 4'd9
  } reg_addr_e;

  // control bits
  localparam int CTL_EN   = 0;
  localparam int CTL_SRST = 1;
  localparam int CTL_FLTX = 8;
  localparam int CTL_FLRX = 9;

  // status bits
  localparam int ST_TXD   = 0;
  localparam int ST_RXD   = 1;
  localparam int ST_LO    = 8;
  localparam int ST_N     = 6;
  localparam int ST_FC    = 9;
  localparam int ST_TC    = 10;
  localparam int ST_MB    = 24;

  // index of each sticky flag inside the sticky vector
  localparam int SK_FC    = ST_FC - ST_LO;
  localparam int SK_TC    = ST_TC - ST_LO;

  localparam int FS_RX_LO = 16;
  localparam int WM_RX_LO = 16;
  localparam int RXS_EMPTY = 1;

  // transmit request: fill level at or below threshold
  function automatic logic at_or_below(input logic [7:0] cnt, input logic [7:0] wm);
    return cnt <= wm;
  endfunction

  // receive request: fill level strictly above threshold
  function automatic logic above(input logic [7:0] cnt, input logic [7:0] wm);
    return cnt > wm;
  endfunction

  function automatic logic [31:0] param_word(input int txl, input int rxl);
    logic [31:0] w;
    w       = '0;
    w[3:0]  = 4'(txl);
    w[11:8] = 4'(rxl);
    return w;
  endfunction

endpackage

// File: rtl/spi_fis_fifo.sv
module spi_fis_fifo #(
  parameter int W    = 32,
  parameter int LOG2 = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic [LOG2:0]   count,
  output logic            full,
  output logic            empty
);
  localparam int DEPTH = 1 << LOG2;
  localparam int CW    = LOG2 + 1;

  logic [W-1:0]      mem [DEPTH];
  logic [LOG2-1:0]   wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_drop_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (count == $past(count)));

  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

endmodule

// File: rtl/spi_fis_events.sv
module spi_fis_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       frame_end,
  input  logic       tc_level,
  input  logic [5:0] w1c,
  output logic [5:0] sticky
);
  import spi_fis_pkg::*;

  logic       tc_prev;
  logic       fc_set;
  logic       tc_set;
  logic [5:0] set_vec;

  assign fc_set = frame_end;
  assign tc_set = tc_level && !tc_prev;

  always_comb begin
    set_vec         = '0;
    set_vec[SK_FC]  = fc_set;
    set_vec[SK_TC]  = tc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky  <= '0;
      tc_prev <= 1'b1;
    end else if (clr) begin
      sticky  <= '0;
      tc_prev <= 1'b1;
    end else begin
      sticky  <= (sticky & ~w1c) | set_vec;
      tc_prev <= tc_level;
    end
  end

  assert_fc_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !clr) |=> sticky[SK_FC]);

  assert_tc_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_level && !tc_prev && !clr) |=> sticky[SK_TC]);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[SK_FC] && !frame_end && !clr) |=> !sticky[SK_FC]);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int DATA_W  = 32,
  parameter int TX_LOG2 = 3,
  parameter int RX_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_busy,
  input  logic              eng_frame_end,
  output logic              irq
);
  import spi_fis_pkg::*;

  localparam int TXC_W = TX_LOG2 + 1;
  localparam int RXC_W = RX_LOG2 + 1;
  localparam int RD_W  = (DATA_W < 32) ? DATA_W : 32;

  // register state
  logic               ctl_en;
  logic [3:0]         ien_q;
  logic [TX_LOG2-1:0] tx_wm;
  logic [RX_LOG2-1:0] rx_wm;

  // decoded strobes
  logic wr_ctrl, wr_stat, wr_ien, wr_fctl, wr_tx, rd_rx;
  logic soft_clr, tx_clr, rx_clr;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_fctl  = reg_wr && (reg_addr == A_FCTL);
  assign wr_tx    = reg_wr && (reg_addr == A_TXDATA);
  assign rd_rx    = reg_rd && (reg_addr == A_RXDATA);
  assign soft_clr = wr_ctrl && reg_wdata[CTL_SRST];
  assign tx_clr   = soft_clr || (wr_ctrl && reg_wdata[CTL_FLTX]);
  assign rx_clr   = soft_clr || (wr_ctrl && reg_wdata[CTL_FLRX]);

  // queues
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [TXC_W-1:0]  tx_count;
  logic [RXC_W-1:0]  rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;

  spi_fis_fifo #(.W(DATA_W), .LOG2(TX_LOG2)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tx_clr),
    .push      (wr_tx),
    .push_data (reg_wdata[DATA_W-1:0]),
    .pop       (eng_tx_pop && ctl_en),
    .head      (tx_head),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  spi_fis_fifo #(.W(DATA_W), .LOG2(RX_LOG2)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .push      (eng_rx_push && ctl_en),
    .push_data (eng_rx_data),
    .pop       (rd_rx),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign eng_tx_valid = ctl_en && !tx_empty;
  assign eng_tx_data  = tx_head;

  // event flags
  logic       tc_level;
  logic [5:0] w1c;
  logic [5:0] sticky;

  assign tc_level = tx_empty && !eng_busy;
  assign w1c      = wr_stat ? reg_wdata[ST_LO +: ST_N] : '0;

  spi_fis_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .frame_end (eng_frame_end),
    .tc_level  (tc_level),
    .w1c       (w1c),
    .sticky    (sticky)
  );

  // live flags
  logic txd_flag, rxd_flag, mb_flag;
  assign txd_flag = at_or_below(8'(tx_count), 8'(tx_wm));
  assign rxd_flag = above(8'(rx_count), 8'(rx_wm));
  assign mb_flag  = ctl_en && eng_busy;

  logic [31:0] stat_w;
  always_comb begin
    stat_w                  = '0;
    stat_w[ST_TXD]          = txd_flag;
    stat_w[ST_RXD]          = rxd_flag;
    stat_w[ST_LO +: ST_N]   = sticky;
    stat_w[ST_MB]           = mb_flag;
  end

  // interrupt
  logic [3:0] irq_src;
  assign irq_src = ien_q & {stat_w[ST_TC], stat_w[ST_FC], stat_w[ST_RXD], stat_w[ST_TXD]};
  assign irq     = |irq_src;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      ien_q  <= '0;
      tx_wm  <= '0;
      rx_wm  <= '0;
    end else if (soft_clr) begin
      ctl_en <= 1'b0;
      ien_q  <= '0;
      tx_wm  <= '0;
      rx_wm  <= '0;
    end else begin
      if (wr_ctrl) ctl_en <= reg_wdata[CTL_EN];
      if (wr_ien)  ien_q  <= {reg_wdata[ST_TC], reg_wdata[ST_FC],
                              reg_wdata[ST_RXD], reg_wdata[ST_TXD]};
      if (wr_fctl) begin
        tx_wm <= reg_wdata[TX_LOG2-1:0];
        rx_wm <= reg_wdata[WM_RX_LO +: RX_LOG2];
      end
    end
  end

  // register reads
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_PARAM:  reg_rdata = param_word(TX_LOG2, RX_LOG2);
      A_CTRL:   reg_rdata[CTL_EN] = ctl_en;
      A_STAT:   reg_rdata = stat_w;
      A_IEN: begin
        reg_rdata[ST_TXD] = ien_q[0];
        reg_rdata[ST_RXD] = ien_q[1];
        reg_rdata[ST_FC]  = ien_q[2];
        reg_rdata[ST_TC]  = ien_q[3];
      end
      A_FCTL: begin
        reg_rdata[TX_LOG2-1:0]          = tx_wm;
        reg_rdata[WM_RX_LO +: RX_LOG2]  = rx_wm;
      end
      A_FSTAT: begin
        reg_rdata[TXC_W-1:0]            = tx_count;
        reg_rdata[FS_RX_LO +: RXC_W]    = rx_count;
      end
      A_RXSTAT: reg_rdata[RXS_EMPTY] = rx_empty;
      A_RXDATA: reg_rdata[RD_W-1:0]  = rx_head[RD_W-1:0];
      default:  reg_rdata = '0;
    endcase
  end

  assert_tx_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_valid |-> (tx_count != '0));

  assert_rx_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !rd_rx && !rx_clr) |=> (rx_count == $past(rx_count)));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!ctl_en && ien_q == '0 && tx_count == '0 && rx_count == '0));

endmodule

// File: tb/sim_spi_fifo_irq_unit.sv
module sim_spi_fifo_irq_unit;
  localparam int TXL = 2;
  localparam int RXL = 2;
  localparam int DW  = 32;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EPUSH = 2'd2, OP_EPOP = 2'd3;
  localparam logic [31:0] PARAM_EXP = (32'(RXL) << 8) | 32'(TXL);
  localparam int NV = 41;

  // {op[73:72], req[71:68], addr[67:64], data[63:32], exp[31:0]}
  localparam logic [73:0] VEC [0:NV-1] = '{
    {OP_RD,   4'd13, 4'd0, 32'h0,        PARAM_EXP},      // R13
    {OP_RD,   4'd1,  4'd2, 32'h0,        32'h00000001},   // R1
    {OP_RD,   4'd1,  4'd6, 32'h0,        32'h00000002},   // R1
    {OP_RD,   4'd1,  4'd5, 32'h0,        32'h00000000},   // R1
    {OP_WR,   4'd2,  4'd1, 32'h1,        32'h0},          // R2 enable
    {OP_WR,   4'd2,  4'd8, 32'hA1,       32'h0},          // R2
    {OP_WR,   4'd2,  4'd8, 32'hA2,       32'h0},
    {OP_WR,   4'd2,  4'd8, 32'hA3,       32'h0},
    {OP_RD,   4'd2,  4'd5, 32'h0,        32'h00000003},   // R2
    {OP_RD,   4'd4,  4'd2, 32'h0,        32'h00000000},   // R4 3 > 0
    {OP_WR,   4'd4,  4'd4, 32'h00010003, 32'h0},          // R4 R5 thresholds
    {OP_RD,   4'd4,  4'd4, 32'h0,        32'h00010003},
    {OP_RD,   4'd4,  4'd2, 32'h0,        32'h00000001},   // R4 3 <= 3
    {OP_WR,   4'd2,  4'd8, 32'hA4,       32'h0},
    {OP_WR,   4'd2,  4'd8, 32'hA5,       32'h0},          // R2 dropped
    {OP_RD,   4'd2,  4'd5, 32'h0,        32'h00000004},
    {OP_RD,   4'd4,  4'd2, 32'h0,        32'h00000000},   // R4 4 > 3
    {OP_EPOP, 4'd2,  4'd0, 32'h0,        32'hA1},         // R2 order
    {OP_EPOP, 4'd2,  4'd0, 32'h0,        32'hA2},
    {OP_RD,   4'd2,  4'd5, 32'h0,        32'h00000002},
    {OP_EPOP, 4'd2,  4'd0, 32'h0,        32'hA3},
    {OP_EPOP, 4'd2,  4'd0, 32'h0,        32'hA4},
    {OP_RD,   4'd2,  4'd5, 32'h0,        32'h00000000},
    {OP_RD,   4'd7,  4'd2, 32'h0,        32'h00000401},   // R7
    {OP_WR,   4'd8,  4'd2, 32'h0,        32'h0},          // R8 zero keeps
    {OP_RD,   4'd8,  4'd2, 32'h0,        32'h00000401},
    {OP_WR,   4'd8,  4'd2, 32'h3F00,     32'h0},          // R8 clear all
    {OP_RD,   4'd8,  4'd2, 32'h0,        32'h00000001},
    {OP_EPUSH,4'd3,  4'd0, 32'h11,       32'h0},          // R3
    {OP_EPUSH,4'd3,  4'd0, 32'h22,       32'h0},
    {OP_RD,   4'd3,  4'd5, 32'h0,        32'h00020000},
    {OP_RD,   4'd5,  4'd2, 32'h0,        32'h00000003},   // R5 2 > 1
    {OP_RD,   4'd3,  4'd6, 32'h0,        32'h00000000},
    {OP_RD,   4'd3,  4'd9, 32'h0,        32'h00000011},
    {OP_RD,   4'd3,  4'd9, 32'h0,        32'h00000022},
    {OP_RD,   4'd3,  4'd9, 32'h0,        32'h00000000},   // R3 empty read
    {OP_RD,   4'd3,  4'd5, 32'h0,        32'h00000000},
    {OP_RD,   4'd3,  4'd6, 32'h0,        32'h00000002},
    {OP_WR,   4'd10, 4'd3, 32'hFFFFFFFF, 32'h0},          // R10
    {OP_RD,   4'd10, 4'd3, 32'h0,        32'h00000603},
    {OP_WR,   4'd10, 4'd3, 32'h0,        32'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          eng_tx_valid;
  logic [DW-1:0] eng_tx_data;
  logic          eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic          eng_busy = 1'b0, eng_frame_end = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit #(.DATA_W(DW), .TX_LOG2(TXL), .RX_LOG2(RXL)) u0 (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .eng_tx_valid, .eng_tx_data, .eng_tx_pop, .eng_rx_push, .eng_rx_data,
    .eng_busy, .eng_frame_end, .irq
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int req, input logic [3:0] addr,
                        input logic [31:0] data, input logic [31:0] exp);
    string tag;
    tag = $sformatf("R%0d", req);
    @(negedge clk);
    case (op)
      OP_WR:    begin reg_wr = 1'b1; reg_addr = addr; reg_wdata = data; end
      OP_RD:    begin reg_rd = 1'b1; reg_addr = addr; end
      OP_EPUSH: begin eng_rx_push = 1'b1; eng_rx_data = data; end
      default:  eng_tx_pop = 1'b1;
    endcase
    #1;
    if (op == OP_RD)   chk(tag, reg_rdata, exp);
    if (op == OP_EPOP) chk(tag, eng_tx_valid ? eng_tx_data : 32'hDEADDEAD, exp);
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0; eng_rx_push = 1'b0; eng_tx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][73:72], int'(VEC[i][71:68]), VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);

    // R10 interrupt follows enabled flags
    run_op(OP_WR, 10, 4'd3, 32'h1, 0);
    chk("R10", {31'b0, irq}, 32'h1);
    run_op(OP_WR, 10, 4'd3, 32'h2, 0);
    chk("R10", {31'b0, irq}, 32'h0);

    // R6 frame end sets bit 9
    @(negedge clk); eng_frame_end = 1'b1;
    @(posedge clk); #1 eng_frame_end = 1'b0;
    run_op(OP_RD, 6, 4'd2, 0, 32'h00000201);
    run_op(OP_WR, 10, 4'd3, 32'h200, 0);
    chk("R10", {31'b0, irq}, 32'h1);
    // R8 set beats clear in the same cycle
    @(negedge clk); eng_frame_end = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h200;
    @(posedge clk); #1 eng_frame_end = 1'b0; reg_wr = 1'b0;
    run_op(OP_RD, 8, 4'd2, 0, 32'h00000201);
    run_op(OP_WR, 8, 4'd2, 32'h200, 0);
    run_op(OP_RD, 8, 4'd2, 0, 32'h00000001);
    run_op(OP_WR, 10, 4'd3, 32'h0, 0);

    // R9 busy, then R7 on busy falling
    eng_busy = 1'b1;
    run_op(OP_RD, 9, 4'd2, 0, 32'h01000001);
    eng_busy = 1'b0;
    run_op(OP_RD, 2, 4'd5, 0, 32'h0);
    run_op(OP_RD, 7, 4'd2, 0, 32'h00000401);
    run_op(OP_WR, 8, 4'd2, 32'h3F00, 0);
    // R8 writes to live bits ignored
    run_op(OP_WR, 8, 4'd2, 32'h01000003, 0);
    run_op(OP_RD, 8, 4'd2, 0, 32'h00000001);

    // R11 transmit flush
    run_op(OP_WR, 11, 4'd8, 32'hB1, 0);
    run_op(OP_WR, 11, 4'd8, 32'hB2, 0);
    run_op(OP_RD, 11, 4'd5, 0, 32'h2);
    run_op(OP_WR, 11, 4'd1, 32'h101, 0);
    run_op(OP_RD, 11, 4'd5, 0, 32'h0);
    run_op(OP_RD, 11, 4'd1, 0, 32'h1);
    run_op(OP_RD, 7, 4'd2, 0, 32'h00000401);
    run_op(OP_WR, 8, 4'd2, 32'h3F00, 0);
    // R11 receive flush beats a same-cycle push
    run_op(OP_EPUSH, 11, 4'd0, 32'h33, 0);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = 32'h44;
    reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h201;
    @(posedge clk); #1 eng_rx_push = 1'b0; reg_wr = 1'b0;
    run_op(OP_RD, 11, 4'd5, 0, 32'h0);

    // R2 R3 R9 while disabled
    run_op(OP_WR, 2, 4'd1, 32'h0, 0);
    run_op(OP_WR, 2, 4'd8, 32'h55, 0);
    chk("R2", {31'b0, eng_tx_valid}, 32'h0);
    run_op(OP_EPUSH, 3, 4'd0, 32'h66, 0);
    run_op(OP_RD, 3, 4'd5, 0, 32'h00000001);
    eng_busy = 1'b1;
    run_op(OP_RD, 9, 4'd2, 0, 32'h00000001);
    eng_busy = 1'b0;

    // R12 software reset
    run_op(OP_WR, 12, 4'd4, 32'h00010002, 0);
    run_op(OP_WR, 12, 4'd3, 32'h3, 0);
    run_op(OP_WR, 12, 4'd1, 32'h1, 0);
    run_op(OP_WR, 12, 4'd1, 32'h2, 0);
    run_op(OP_RD, 12, 4'd1, 0, 32'h0);
    run_op(OP_RD, 12, 4'd4, 0, 32'h0);
    run_op(OP_RD, 12, 4'd3, 0, 32'h0);
    run_op(OP_RD, 12, 4'd5, 0, 32'h0);
    run_op(OP_RD, 12, 4'd2, 0, 32'h00000001);
    chk("R12", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule